// File: doc/BRIEF.md
# Least-Frequently-Used Victim Selector

This block tracks how often each way of a set-associative cache has been used and names the way to replace when a miss needs a line. Every set holds one small use counter per way. A hit to a way raises that way's counter by one. A fill after a miss, or an eviction, returns the counter to zero. The counters stop at their all-ones value and do not wrap.

The selection is purely combinational. It reads the counters of the addressed set and the per-way valid bits, and it produces a victim in the same cycle. The scan starts with way 0 as the candidate, carrying way 0's count as the current lowest. It then walks way 1 upward. The first invalid way it meets wins at once. Otherwise a way takes over only when its count is strictly lower than the current lowest, so a tie keeps the lower index. The valid bit of way 0 is never examined.

A single set index addresses both the victim lookup and the counter updates. Tag compare and data storage belong to the surrounding cache.

Top module: `lfu_victim_sel`

## Requirements
- R1: After reset every counter is zero, so with all ways valid the victim of every set is way 0.
- R2: An update with the hit flag set (upd_hit=1) raises the counter of upd_way in set set_idx by one at the next rising clock edge.
- R3: A counter at its maximum value 2**CNT_W-1 stays at that value on a further hit.
- R4: An update with the hit flag clear (upd_hit=0, a fill) sets the counter of upd_way in set set_idx to zero at the next rising clock edge.
- R5: An eviction strobe sets the counter of evict_way in set set_idx to zero at the next rising clock edge.
- R6: When a hit and an eviction name the same way in the same cycle, the counter becomes zero.
- R7: An update or eviction changes only the counter of the addressed way in the addressed set. With both strobes low no counter changes.
- R8: If any of ways 1 to NUM_WAYS-1 has its valid bit (way_valid[w]=1 means valid) low, the victim is the lowest-indexed such way.
- R9: If ways 1 to NUM_WAYS-1 are all valid, the victim has the lowest count in the set. Among equal lowest counts it is the lowest index.
- R10: The valid bit of way 0 does not affect the choice. With way 0 invalid and all other ways valid, way 0 is still chosen unless another way has a strictly lower count.
- R11: victim_way follows changes of set_idx and way_valid in the same cycle, with no clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| set_idx | input | $clog2(NUM_SETS) | Set addressed by the lookup and by the updates |
| way_valid | input | NUM_WAYS | Valid bit per way of the addressed set |
| upd_en | input | 1 | Hit or fill update strobe |
| upd_way | input | $clog2(NUM_WAYS) | Way targeted by the update |
| upd_hit | input | 1 | 1: hit (increment), 0: fill (clear) |
| evict_en | input | 1 | Eviction strobe |
| evict_way | input | $clog2(NUM_WAYS) | Way being evicted |
| victim_way | output | $clog2(NUM_WAYS) | Way chosen for replacement |

## Verification
The victim is combinational, so it is due in the same timestep as a change of set_idx or way_valid. The bench samples it 1 ns after driving those inputs, with no clock edge in between. Counter changes take effect at the first rising edge that sees a strobe. Strobes are therefore driven on a falling edge and withdrawn on the next falling edge, and the victim is read only after that. A reference model of the counters applies each operation at that same point. After each operation the bench sweeps all valid-bit patterns over the touched set and one other set.

// File: rtl/lfu_pkg.sv
package lfu_pkg;
   // index width that stays at least one bit for degenerate sizes
   function automatic int idx_w(input int n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction
endpackage

// File: rtl/lfu_cnt_cell.sv
module lfu_cnt_cell #(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             inc,
   output logic [CNT_W-1:0] cnt
);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      cnt <= '0;
      else if (clr)                    cnt <= '0;
      else if (inc && cnt != CNT_MAX)  cnt <= cnt + 1'b1;
   end

   AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (cnt == '0));                                             // R4
   AST_INC_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      (inc && !clr && cnt != CNT_MAX) |=> (cnt == $past(cnt) + 1'b1));  // R2
   AST_SAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (inc && !clr && cnt == CNT_MAX) |=> (cnt == CNT_MAX));            // R3
   AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!inc && !clr) |=> $stable(cnt));                                 // R7
endmodule

// File: rtl/lfu_scan.sv
module lfu_scan #(
   parameter int NUM_WAYS = 4,
   parameter int CNT_W    = 4,
   parameter int WAY_W    = 2
) (
   input  logic [NUM_WAYS-1:0][CNT_W-1:0] cnt_vec,
   input  logic [NUM_WAYS-1:0]            valid,
   output logic [WAY_W-1:0]               victim
);
   logic [CNT_W-1:0] lowest;
   logic             stop;

   always_comb begin
      victim = '0;
      lowest = cnt_vec[0];
      stop   = 1'b0;
      for (int i = 1; i < NUM_WAYS; i++) begin
         if (!stop) begin
            if (!valid[i]) begin
               victim = WAY_W'(i);
               stop   = 1'b1;
            end else if (cnt_vec[i] < lowest) begin
               victim = WAY_W'(i);
               lowest = cnt_vec[i];
            end
         end
      end
   end
endmodule

// File: rtl/lfu_victim_sel.sv
module lfu_victim_sel #(
   parameter int NUM_WAYS = 4,
   parameter int NUM_SETS = 16,
   parameter int CNT_W    = 4,
   localparam int WAY_W   = lfu_pkg::idx_w(NUM_WAYS),
   localparam int SET_W   = lfu_pkg::idx_w(NUM_SETS)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [SET_W-1:0]    set_idx,
   input  logic [NUM_WAYS-1:0] way_valid,
   input  logic                upd_en,
   input  logic [WAY_W-1:0]    upd_way,
   input  logic                upd_hit,
   input  logic                evict_en,
   input  logic [WAY_W-1:0]    evict_way,
   output logic [WAY_W-1:0]    victim_way
);
   if (NUM_WAYS < 2) begin : g_bad_ways
      $error("lfu_victim_sel: NUM_WAYS must be at least 2");
   end
   if (NUM_SETS < 2) begin : g_bad_sets
      $error("lfu_victim_sel: NUM_SETS must be at least 2");
   end
   if (CNT_W < 1) begin : g_bad_cnt
      $error("lfu_victim_sel: CNT_W must be at least 1");
   end

   logic [CNT_W-1:0]                cnt_all [NUM_SETS][NUM_WAYS];
   logic [NUM_WAYS-1:0][CNT_W-1:0] sel_cnt;

   for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
      for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
         logic hit_sel, fill_sel, ev_sel, clr_c, inc_c;
         assign hit_sel  = (set_idx == SET_W'(s)) && upd_en && upd_hit
                           && (upd_way == WAY_W'(w));
         assign fill_sel = (set_idx == SET_W'(s)) && upd_en && !upd_hit
                           && (upd_way == WAY_W'(w));
         assign ev_sel   = (set_idx == SET_W'(s)) && evict_en
                           && (evict_way == WAY_W'(w));
         assign clr_c    = fill_sel || ev_sel;
         assign inc_c    = hit_sel && !ev_sel;

         lfu_cnt_cell #(.CNT_W(CNT_W)) u_cell (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (clr_c),
            .inc   (inc_c),
            .cnt   (cnt_all[s][w])
         );
      end
   end

   always_comb begin
      for (int w = 0; w < NUM_WAYS; w++) sel_cnt[w] = cnt_all[set_idx][w];
   end

   lfu_scan #(
      .NUM_WAYS (NUM_WAYS),
      .CNT_W    (CNT_W),
      .WAY_W    (WAY_W)
   ) u_scan (
      .cnt_vec (sel_cnt),
      .valid   (way_valid),
      .victim  (victim_way)
   );

   AST_VICTIM_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
      (!(&way_valid[NUM_WAYS-1:1])) |-> !way_valid[victim_way]);        // R8

   for (genvar w = 0; w < NUM_WAYS; w++) begin : g_chk
      AST_VICTIM_MIN: assert property (@(posedge clk) disable iff (!rst_n)
         (&way_valid[NUM_WAYS-1:1]) |-> (sel_cnt[victim_way] <= sel_cnt[w])); // R9
      AST_TIE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
         ((&way_valid[NUM_WAYS-1:1]) && sel_cnt[victim_way] == sel_cnt[w])
         |-> (victim_way <= WAY_W'(w)));                                 // R9
   end
endmodule

// File: tb/lfu_victim_sel_tb.sv
`timescale 1ns/1ps
module lfu_victim_sel_tb;
   localparam int NW = 4;
   localparam int NS = 4;
   localparam int CW = 3;
   localparam int MAXC = (1 << CW) - 1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [1:0]    set_idx = '0;
   logic [NW-1:0] way_valid = '1;
   logic          upd_en = 1'b0;
   logic [1:0]    upd_way = '0;
   logic          upd_hit = 1'b0;
   logic          evict_en = 1'b0;
   logic [1:0]    evict_way = '0;
   logic [1:0]    victim_way;

   int tests = 0;
   int fails = 0;
   int model [NS][NW];
   logic [15:0] lfsr = 16'hACE1;

   always #5 clk = ~clk;

   lfu_victim_sel #(.NUM_WAYS(NW), .NUM_SETS(NS), .CNT_W(CW)) u_dut (
      .clk(clk), .rst_n(rst_n), .set_idx(set_idx), .way_valid(way_valid),
      .upd_en(upd_en), .upd_way(upd_way), .upd_hit(upd_hit),
      .evict_en(evict_en), .evict_way(evict_way), .victim_way(victim_way));

   function automatic int exp_victim(input int s, input logic [NW-1:0] v);
      int cand = 0;
      int low = model[s][0];
      for (int i = 1; i < NW; i++) begin
         if (!v[i]) return i;
         if (model[s][i] < low) begin cand = i; low = model[s][i]; end
      end
      return cand;
   endfunction

   task automatic check_one(input int s, input logic [NW-1:0] v, input string tag);
      int e;
      set_idx = 2'(s); way_valid = v;
      #1;
      e = exp_victim(s, v);
      tests++;
      if (int'(victim_way) != e) begin
         fails++;
         $display("FAIL %s set=%0d valid=%b actual=%0d expected=%0d", tag, s, v, victim_way, e);
      end
   endtask

   task automatic sweep(input int s, input string tag);
      for (int v = 0; v < (1 << NW); v++) check_one(s, NW'(v), tag);
   endtask

   // drive on falling edge, counters move at the rising edge, withdraw on next falling edge
   task automatic op(input int s, input bit ue, input int uw, input bit uh,
                     input bit ee, input int ew);
      @(negedge clk);
      set_idx = 2'(s); upd_en = ue; upd_way = 2'(uw); upd_hit = uh;
      evict_en = ee; evict_way = 2'(ew);
      @(negedge clk);
      upd_en = 1'b0; evict_en = 1'b0;
      if (ue) begin
         if (uh) begin if (model[s][uw] < MAXC) model[s][uw]++; end
         else model[s][uw] = 0;
      end
      if (ee) model[s][ew] = 0;
   endtask

   initial begin
      #2_000_000;
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      for (int s = 0; s < NS; s++) for (int w = 0; w < NW; w++) model[s][w] = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      for (int s = 0; s < NS; s++) check_one(s, '1, "R1");
      // R10: way 0 invalid, all equal counts -> way 0
      check_one(0, 4'b1110, "R10");
      op(0, 1, 0, 1, 0, 0); op(0, 1, 0, 1, 0, 0);
      check_one(0, 4'b1110, "R10");                   // others lower -> way 1
      op(0, 1, 1, 1, 0, 0); op(0, 1, 1, 1, 0, 0);
      op(0, 1, 2, 1, 0, 0); op(0, 1, 2, 1, 0, 0);
      op(0, 1, 3, 1, 0, 0); op(0, 1, 3, 1, 0, 0);
      check_one(0, 4'b1110, "R10");                   // all 2 -> way 0
      // R2: increments, R9 ordering
      op(0, 1, 0, 1, 0, 0);
      check_one(0, '1, "R2");                         // way 0 = 3, lowest way 1
      sweep(0, "R2");
      // R3: saturation, way1 hit 10 times, others to max
      for (int k = 0; k < 10; k++) op(2, 1, 1, 1, 0, 0);
      for (int k = 0; k < MAXC; k++) begin
         op(2, 1, 0, 1, 0, 0); op(2, 1, 2, 1, 0, 0); op(2, 1, 3, 1, 0, 0);
      end
      check_one(2, '1, "R3");
      sweep(2, "R3");
      // R4 / R5
      for (int w = 0; w < NW; w++) begin op(1, 1, w, 1, 0, 0); op(1, 1, w, 1, 0, 0); end
      op(1, 1, 2, 0, 0, 0);
      check_one(1, '1, "R4");
      for (int k = 0; k < 3; k++) op(1, 1, 2, 1, 0, 0);
      op(1, 0, 0, 0, 1, 3);
      check_one(1, '1, "R5");
      // R6: hit and evict same way
      for (int k = 0; k < 3; k++) op(3, 1, 1, 1, 0, 0);
      op(3, 1, 0, 1, 0, 0); op(3, 1, 2, 1, 0, 0); op(3, 1, 3, 1, 0, 0);
      op(3, 1, 1, 1, 1, 1);
      check_one(3, '1, "R6");
      // R7: untouched sets
      sweep(0, "R7");
      // R8: invalid ways
      sweep(1, "R8");
      // R11: victim follows set_idx / way_valid without an edge
      check_one(2, 4'b1011, "R11");
      check_one(3, '1, "R11");
      // mixed operation sequence
      for (int n = 0; n < 300; n++) begin
         int s, uw, ew, k;
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         s = int'(lfsr[3:2]); uw = int'(lfsr[5:4]); ew = int'(lfsr[7:6]);
         k = int'(lfsr[10:8]);
         case (k)
            0, 1, 2, 3: op(s, 1, uw, 1, 0, 0);
            4:          op(s, 1, uw, 0, 0, 0);
            5:          op(s, 0, 0, 0, 1, ew);
            6:          op(s, 1, uw, 1, 1, ew);
            default:    op(s, 1, uw, 0, 1, ew);
         endcase
         sweep(s, "R9");
         sweep((s + 1) % NS, "R7");
      end
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule